// File: doc/BRIEF.md
# Programmable Timer Counter Channel

This block is a single channel of a 16-bit timer. A power-of-two prescaler, with its own enable, sets the count rate. The counter runs in one of two modes. In free-running mode it wraps at the top of its range. In interval mode it restarts after it reaches a programmable limit. Three compare registers raise events when the count equals them. The first of these also flips a waveform output.

Software uses a flat register port. A one-cycle write strobe carries an address and a data word. Read data is a combinational function of the address. The wrap event and the three compare events each latch a sticky status bit, which software clears by writing ones to it. A single interrupt line reports any status bit whose enable is set. Writes to the timing configuration take effect only while the counter is stopped. The `running` output lets software check this before it writes.

Top module: `tmr_channel`

Register addresses: 0 control, 1 clock setup, 2 prescaler code (read only), 3 interval, 4/5/6 compare 0/1/2, 7 interrupt enable, 8 status, 9 count (read only).

## Requirements
- R1: After reset, control reads 0, the count is 0, the prescaler code reads 16, and `irq`, `wave_out` and `running` are all low.
- R2: Clock setup bit 0 enables the prescaler and bits 4:1 hold an exponent n. When the prescaler is enabled, the count advances once every 2^(n+1) clocks. When it is disabled, the count advances every clock. The prescaler code register reads n when enabled and 16 when disabled.
- R3: Control bit 1 clear selects free-running mode. In this mode the count wraps from 0xFFFF to 0 and sets status bit 0.
- R4: Control bit 1 set selects interval mode. In this mode the count returns to 0 on the step after it equals the interval register, and sets status bit 0.
- R5: When the count equals compare register i on a count step, status bit i+1 is set.
- R6: Control bit 2 enables the waveform and bit 3 gives its starting level while the counter is stopped. While the counter runs, the level flips on each count step at which the count equals compare 0. With the waveform disabled, `wave_out` is low.
- R7: Writing status clears each bit written as 1 and leaves the bits written as 0 unchanged.
- R8: `irq` is high exactly when some status bit and its interrupt-enable bit (same position) are both set.
- R9: Control bit 0 starts the counter and is shown on `running`. While it is set, writes to clock setup, interval and compare registers are ignored.
- R10: Writing control with bit 4 set forces the count to 0 at that clock edge. Bit 4 always reads back as 0.
- R11: Each compare register reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| wave_out | output | 1 | Waveform output |
| running | output | 1 | Counter started flag |

## Verification
The bound checker watches the following on every cycle:
- the count holds between steps;
- the count increments in free-running mode;
- the count wraps in both modes, together with the status bit each wrap sets;
- the forced clear takes effect;
- the interval register stays fixed while the counter runs;
- the waveform level stays put between compare-0 hits.

Other behaviours need the bench's scenarios:
- the division ratio of each prescaler setting;
- the prescaler code read-back;
- the waveform's starting polarity and period;
- write-one-to-clear behaviour;
- interrupt masking;
- compare read-back.

// File: rtl/tmr_pkg.sv
// Shared constants for the timer channel: register addresses and event layout.
package tmr_pkg;
    localparam int unsigned ADDR_W    = 4;
    localparam int unsigned NUM_MATCH = 3;
    localparam int unsigned NUM_EVT   = NUM_MATCH + 1;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_CLK    = 4'd1;
    localparam logic [ADDR_W-1:0] A_PSCODE = 4'd2;
    localparam logic [ADDR_W-1:0] A_INTV   = 4'd3;
    localparam logic [ADDR_W-1:0] A_CMP0   = 4'd4;
    localparam logic [ADDR_W-1:0] A_IEN    = 4'd7;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'd8;
    localparam logic [ADDR_W-1:0] A_COUNT  = 4'd9;

    // Control word bit positions
    localparam int unsigned C_RUN  = 0;
    localparam int unsigned C_MODE = 1;
    localparam int unsigned C_WEN  = 2;
    localparam int unsigned C_POL  = 3;
    localparam int unsigned C_CLR  = 4;
endpackage

// File: rtl/tmr_prescaler.sv
// Prescaler: emits one count step every 2^(exp+1) clocks when enabled,
// every clock when disabled. Assumes run/clr come from the register block;
// the phase counter restarts whenever the counter is stopped or cleared.
module tmr_prescaler #(
    parameter int unsigned EXP_W = 4,
    localparam int unsigned PW   = 2 ** EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             ps_en,
    input  logic [EXP_W-1:0] ps_exp,
    output logic             tick
);
    logic [PW-1:0] phase;
    logic [PW:0]   span;
    logic [PW-1:0] last;

    // Division ratio 2^(exp+1) and its terminal phase value
    always_comb begin
        span = {{PW{1'b0}}, 1'b1} << ({1'b0, ps_exp} + (EXP_W+1)'(1));
        last = PW'(span - (PW+1)'(1));
    end

    assign tick = run && (!ps_en || (phase == last));

    // Phase counter that rolls over on every step
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clr || tick) begin
            phase <= '0;
        end else begin
            phase <= phase + PW'(1);
        end
    end
endmodule

// File: rtl/tmr_core.sv
// Count engine: counter with free-running/interval wrap, compare detection
// and waveform level. Assumes tick is already qualified by the run state.
module tmr_core #(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned NUM_MATCH = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            run,
    input  logic                            tick,
    input  logic                            clr,
    input  logic                            intv_mode,
    input  logic                            pol,
    input  logic [CNT_W-1:0]                intv,
    input  logic [NUM_MATCH-1:0][CNT_W-1:0] cmp,
    output logic [CNT_W-1:0]                count,
    output logic                            wave_lvl,
    output logic [NUM_MATCH:0]              evt
);
    logic                 wrap;
    logic [NUM_MATCH-1:0] hit;

    // Wrap condition depends on the selected mode
    assign wrap = intv_mode ? (count == intv) : (count == {CNT_W{1'b1}});

    // One comparator per compare register
    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_cmp
        assign hit[i]    = tick && (count == cmp[i]);
        assign evt[i+1]  = hit[i];
    end
    assign evt[0] = tick && wrap;

    // Counter: forced clear first, then step or wrap
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (tick) begin
            count <= wrap ? '0 : count + CNT_W'(1);
        end
    end

    // Waveform level: preset to polarity when stopped, flips on compare 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_lvl <= 1'b0;
        end else if (!run) begin
            wave_lvl <= pol;
        end else if (hit[0]) begin
            wave_lvl <= ~wave_lvl;
        end
    end
endmodule

// File: rtl/tmr_regs.sv
// Register file: control, clock setup, interval, compares, interrupt enable
// and write-one-to-clear status. Timing configuration is locked while running.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned EXP_W = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            reg_wr,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic [CNT_W-1:0]                reg_wdata,
    output logic [CNT_W-1:0]                reg_rdata,
    input  logic [CNT_W-1:0]                count,
    input  logic [NUM_EVT-1:0]              evt,
    output logic                            run,
    output logic                            intv_mode,
    output logic                            wave_en,
    output logic                            pol,
    output logic                            cnt_clr,
    output logic                            ps_en,
    output logic [EXP_W-1:0]                ps_exp,
    output logic [CNT_W-1:0]                intv,
    output logic [NUM_MATCH-1:0][CNT_W-1:0] cmp,
    output logic [NUM_EVT-1:0]              ien,
    output logic [NUM_EVT-1:0]              stat
);
    localparam logic [EXP_W:0] PS_OFF_CODE = (EXP_W+1)'(2 ** EXP_W);

    logic wr_ctrl, cfg_ok;
    logic [EXP_W:0] ps_code;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign cfg_ok  = reg_wr && !run;
    assign cnt_clr = wr_ctrl && reg_wdata[C_CLR];

    // Control fields, always writable so software can stop the counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {run, intv_mode, wave_en, pol} <= '0;
        end else if (wr_ctrl) begin
            run       <= reg_wdata[C_RUN];
            intv_mode <= reg_wdata[C_MODE];
            wave_en   <= reg_wdata[C_WEN];
            pol       <= reg_wdata[C_POL];
        end
    end

    // Clock setup and interval, accepted only while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_en  <= 1'b0;
            ps_exp <= '0;
            intv   <= '0;
        end else if (cfg_ok) begin
            if (reg_addr == A_CLK) begin
                ps_en  <= reg_wdata[0];
                ps_exp <= reg_wdata[EXP_W:1];
            end
            if (reg_addr == A_INTV) begin
                intv <= reg_wdata;
            end
        end
    end

    // Compare registers, one per generate slot, locked while running
    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_cmp_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp[i] <= '0;
            end else if (cfg_ok && (reg_addr == A_CMP0 + ADDR_W'(i))) begin
                cmp[i] <= reg_wdata;
            end
        end
    end

    // Interrupt enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien <= '0;
        end else if (reg_wr && (reg_addr == A_IEN)) begin
            ien <= reg_wdata[NUM_EVT-1:0];
        end
    end

    // Sticky status: new events win over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
        end else if (reg_wr && (reg_addr == A_STAT)) begin
            stat <= (stat & ~reg_wdata[NUM_EVT-1:0]) | evt;
        end else begin
            stat <= stat | evt;
        end
    end

    assign ps_code = ps_en ? {1'b0, ps_exp} : PS_OFF_CODE;

    // Read-back multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:   reg_rdata = CNT_W'({pol, wave_en, intv_mode, run});
            A_CLK:    reg_rdata = CNT_W'({ps_exp, ps_en});
            A_PSCODE: reg_rdata = CNT_W'(ps_code);
            A_INTV:   reg_rdata = intv;
            A_IEN:    reg_rdata = CNT_W'(ien);
            A_STAT:   reg_rdata = CNT_W'(stat);
            A_COUNT:  reg_rdata = count;
            default: begin
                for (int i = 0; i < NUM_MATCH; i++) begin
                    if (reg_addr == A_CMP0 + ADDR_W'(i)) begin
                        reg_rdata = cmp[i];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/tmr_channel.sv
// Timer channel top: joins the register file, prescaler and count engine and
// forms the interrupt and waveform outputs. Assumes a single clock domain.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned EXP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              wave_out,
    output logic              running
);
    logic                            run_q, mode_q, wen_q, pol_q, cnt_clr;
    logic                            ps_en, tick, wave_lvl;
    logic [EXP_W-1:0]                ps_exp;
    logic [CNT_W-1:0]                count, intv_q;
    logic [NUM_MATCH-1:0][CNT_W-1:0] cmp_q;
    logic [NUM_EVT-1:0]              ien_q, stat_q, evt;

    tmr_regs #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count(count), .evt(evt),
        .run(run_q), .intv_mode(mode_q), .wave_en(wen_q), .pol(pol_q),
        .cnt_clr(cnt_clr), .ps_en(ps_en), .ps_exp(ps_exp), .intv(intv_q),
        .cmp(cmp_q), .ien(ien_q), .stat(stat_q)
    );

    tmr_prescaler #(.EXP_W(EXP_W)) u_ps (
        .clk(clk), .rst_n(rst_n), .run(run_q), .clr(cnt_clr),
        .ps_en(ps_en), .ps_exp(ps_exp), .tick(tick)
    );

    tmr_core #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_core (
        .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick), .clr(cnt_clr),
        .intv_mode(mode_q), .pol(pol_q), .intv(intv_q), .cmp(cmp_q),
        .count(count), .wave_lvl(wave_lvl), .evt(evt)
    );

    assign irq      = |(stat_q & ien_q);
    assign wave_out = wen_q && wave_lvl;
    assign running  = run_q;
endmodule

// File: rtl/tmr_channel_chk.sv
// Property checker for the timer channel, bound to the top module.
module tmr_channel_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             mode,
    input logic             tick,
    input logic             cnt_clr,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] intv,
    input logic [CNT_W-1:0] cmp0,
    input logic             wave_lvl,
    input logic             stat0
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_clr) |=> $stable(count));

    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_clr && !mode && count != {CNT_W{1'b1}})
        |=> count == CNT_W'($past(count) + CNT_W'(1)));

    p_ovf_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_clr && !mode && count == {CNT_W{1'b1}})
        |=> (count == '0) && stat0);

    p_intv_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_clr && mode && count == intv) |=> (count == '0) && stat0);

    p_wave_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !(tick && count == cmp0)) |=> $stable(wave_lvl));

    p_cfg_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(intv));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> count == '0);
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .running(run_q), .mode(mode_q), .tick(tick),
    .cnt_clr(cnt_clr), .count(count), .intv(intv_q), .cmp0(cmp_q[0]),
    .wave_lvl(wave_lvl), .stat0(stat_q[0])
);

// File: tb/tmr_channel_tb.sv
// Self-checking bench: sweeps prescaler settings, both count modes, compares,
// waveform period, status clearing and the configuration lock.
module tmr_channel_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_CTRL = 0, A_CLK = 1, A_PSC = 2, A_INTV = 3,
        A_CMP0 = 4, A_IEN = 7, A_STAT = 8, A_CNT = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq, wave_out, running;
    int checks = 0;
    int errors = 0;
    logic [15:0] d;

    tmr_channel u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .wave_out(wave_out), .running(running)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Stop, clear count and pending status
    task automatic halt();
        wr(A_CTRL, 16'h0010);
        wr(A_STAT, 16'h000F);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_CTRL, d); check("R1 ctrl", d, 0);
        rd(A_CNT, d);  check("R1 count", d, 0);
        rd(A_PSC, d);  check("R1 prescaler code", d, 16);
        check("R1 outputs", {irq, wave_out, running}, 0);

        // R2 prescaler sweep: disabled plus exponents 0..3
        for (int k = -1; k < 4; k++) begin
            int div;
            halt();
            div = (k < 0) ? 1 : (1 << (k + 1));
            wr(A_CLK, (k < 0) ? 16'h0 : 16'(((k & 15) << 1) | 1));
            rd(A_PSC, d); check("R2 code", d, (k < 0) ? 16 : k);
            wr(A_CTRL, 16'h0001);
            repeat (37) @(posedge clk);
            @(negedge clk);
            rd(A_CNT, d); check("R2 divided count", d, 37 / div);
        end
        halt();
        wr(A_CLK, 16'h0);

        // R11 compare read-back sweep
        for (int i = 0; i < 3; i++) begin
            for (int v = 0; v < 4; v++) begin
                logic [15:0] pat;
                pat = 16'(16'hA5C3 ^ (v * 16'h1111) ^ i);
                wr(4'(A_CMP0 + i), pat);
                rd(4'(A_CMP0 + i), d); check("R11 compare read-back", d, pat);
            end
        end

        // R4 interval mode
        for (int i = 0; i < 3; i++) wr(4'(A_CMP0 + i), 16'h0100);
        wr(A_INTV, 16'd5);
        wr(A_CTRL, 16'h0003);
        for (int j = 1; j <= 14; j++) begin
            step();
            rd(A_CNT, d); check("R4 interval count", d, j % 6);
        end
        rd(A_STAT, d); check("R4 interval status", d & 1, 1);
        // R9 configuration ignored while running
        check("R9 running", running, 1);
        wr(A_INTV, 16'd9);
        wr(A_CMP0, 16'h0042);
        halt();
        rd(A_INTV, d); check("R9 interval locked", d, 5);
        rd(A_CMP0, d); check("R9 compare locked", d, 16'h0100);

        // R5, R7, R8 compares, status and interrupt
        wr(A_CMP0, 16'd100);
        wr(4'(A_CMP0 + 1), 16'd3);
        wr(4'(A_CMP0 + 2), 16'd7);
        wr(A_INTV, 16'd20);
        wr(A_IEN, 16'b0100);
        wr(A_CTRL, 16'h0003);
        for (int j = 1; j <= 9; j++) begin
            step();
            rd(A_STAT, d);
            check("R5 compare status", d, ((j >= 4) ? 4 : 0) | ((j >= 8) ? 8 : 0));
            check("R8 irq masked", irq, (j >= 4) ? 1 : 0);
        end
        wr(A_CTRL, 16'h0002);
        wr(A_STAT, 16'b0100);
        rd(A_STAT, d); check("R7 clear one bit", d, 8);
        check("R8 irq after clear", irq, 0);
        wr(A_STAT, 16'h0000);
        rd(A_STAT, d); check("R7 zero write no effect", d, 8);
        wr(A_IEN, 16'b1000);
        check("R8 irq other bit", irq, 1);
        wr(A_IEN, 16'h0);

        // R6 waveform: compare 0 = 2, interval 4, polarity high
        halt();
        wr(A_CMP0, 16'd2);
        wr(A_INTV, 16'd4);
        wr(A_CTRL, 16'h0008);
        check("R6 disabled low", wave_out, 0);
        wr(A_CTRL, 16'h000C);
        check("R6 start level", wave_out, 1);
        wr(A_CTRL, 16'h000F);
        for (int j = 1; j <= 16; j++) begin
            int flips;
            step();
            flips = (j >= 3) ? ((j - 3) / 5 + 1) : 0;
            check("R6 waveform level", wave_out, 1 ^ (flips & 1));
        end
        wr(A_CTRL, 16'h0003);
        check("R6 disabled while running", wave_out, 0);

        // R3 free-running wrap
        halt();
        wr(A_CTRL, 16'h0001);
        repeat (65535) @(posedge clk);
        @(negedge clk);
        rd(A_CNT, d);  check("R3 top of range", d, 16'hFFFF);
        rd(A_STAT, d); check("R3 no wrap yet", d & 1, 0);
        step();
        rd(A_CNT, d);  check("R3 wrapped", d, 0);
        rd(A_STAT, d); check("R3 wrap status", d & 1, 1);

        // R10 forced clear while running
        repeat (10) step();
        wr(A_CTRL, 16'h0011);
        rd(A_CNT, d);  check("R10 cleared", d, 0);
        rd(A_CTRL, d); check("R10 bit reads zero", d, 1);
        step();
        rd(A_CNT, d);  check("R10 resumes", d, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule